// File: doc/BRIEF.md
# Programmable Data Clock Divider with Source Polarity

This block derives a data clock from one of four clock sources: a chip-internal clock or one of three external clock pins. Each external pin has its own polarity bit. The bit chooses whether the rising or the falling edge of that pin counts as the active edge. The internal clock always counts its rising edge. The selected, polarity-adjusted clock is divided by an integer from 1 to 256. The divide value is an 8-bit field plus one.

The divider is a small state machine clocked by the effective source edge. It has four states:
- `ST_IDLE`: held in reset, output low.
- `ST_HIGH`: output high while the count runs down.
- `ST_LOW`: output low while the count runs down.
- `ST_PASS`: bypass for a zero divide field, where the output follows the effective clock.

The state machine has these transitions:
- IDLE to HIGH, or IDLE to PASS, on the first active edge after reset.
- HIGH to LOW when the high count expires.
- LOW to HIGH, or LOW to PASS, at the reload.
- PASS to PASS, or PASS to HIGH, at every edge, because every edge of the bypass is a reload.
- Any state to IDLE while reset is asserted.

The divide field is captured only at a reload, so a new value never cuts a period short. Source and polarity are configured while reset is held.

Top module: `prog_clkdiv`

## Requirements
- R1: The source select picks the divider clock: 0 selects the internal clock, 1 selects external pin 0, 2 selects external pin 1, and 3 selects external pin 2.
- R2: Polarity bit i belongs to external pin i. A value of 0 makes the rising edge of that pin active, and 1 makes the falling edge active. The internal clock is always rising-edge active. The output changes only at active edges, or at both edges in bypass.
- R3: For a divide field d, the output period is d+1 active edges.
- R4: When d is odd, the output is high for (d+1)/2 active edges and low for (d+1)/2 active edges.
- R5: When d is even and non-zero (d = 2p), the output is high for p+1 active edges and low for p active edges.
- R6: When d is 0 (ST_PASS), the output equals the effective clock: high after each active edge and low after each inactive edge.
- R7: A synchronous active-high reset puts the machine in ST_IDLE and holds the output low.
- R8: The first rising output edge comes with the first active edge after reset is released.
- R9: The divide field is sampled only at a reload, which is the start of each high phase. In bypass, every active edge is a reload.
- R10: Source and polarity change only while reset is held. After such a change the output stays low until release, and the new source then drives the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal source clock, always rising-edge active |
| ext_clk | input | 3 | External source clock pins |
| ext_pol | input | 3 | Per-pin edge polarity, 1 = falling edge active |
| src_sel | input | 2 | Source select |
| div_val | input | 8 | Divide field, ratio = value + 1 |
| rst | input | 1 | Synchronous active-high reset, in the effective-clock domain |
| clk_out | output | 1 | Divided data clock |

## Verification
A vector table visits every source with both polarities and uses divide fields 1, 2, 3, 4, 5, 6, 7, 8 and 255. These separate the equal-halves rule for even ratios from the one-longer-high rule for odd ratios, and cover the ratio at the top of the range. The output is sampled after every active edge and again after every inactive edge. A divider that runs on the wrong edge, or on the wrong pin, therefore shows up as a change at the inactive edge or as a period of the wrong length. Directed runs cover the bypass ratio and its exit, a divide change in the middle of a period, and reset asserted while the divider is running.

// File: rtl/prog_clkdiv_pkg.sv
package prog_clkdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_PASS = 2'd3
    } div_state_t;
endpackage

// File: rtl/clk_src_mux.sv
module clk_src_mux #(
    parameter int NUM_EXT = 3,
    localparam int SEL_W  = $clog2(NUM_EXT + 1)
) (
    input  logic               clk_int,
    input  logic [NUM_EXT-1:0] ext_clk,
    input  logic [NUM_EXT-1:0] ext_pol,
    input  logic [SEL_W-1:0]   src_sel,
    output logic               clk_eff
);
    logic [NUM_EXT:0] cand;

    assign cand[0] = clk_int;   // internal source: fixed positive polarity

    generate
        for (genvar i = 0; i < NUM_EXT; i++) begin : g_pol
            assign cand[i+1] = ext_clk[i] ^ ext_pol[i];
        end
    endgenerate

    always_comb begin
        clk_eff = 1'b0;
        for (int k = 0; k <= NUM_EXT; k++) begin
            if (src_sel == SEL_W'(k)) clk_eff = cand[k];
        end
    end
endmodule

// File: rtl/div_phase_len.sv
module div_phase_len #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] div_f,
    output logic [DIV_W-1:0] hi_m1,
    output logic [DIV_W-1:0] lo_m1
);
    // high = d/2 + 1, low = d + 1 - high  (counts minus one)
    always_comb begin
        hi_m1 = div_f >> 1;
        if (div_f == '0) lo_m1 = '0;
        else             lo_m1 = div_f - (div_f >> 1) - 1'b1;
    end
endmodule

// File: rtl/div_fsm.sv
module div_fsm
    import prog_clkdiv_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_in,
    output div_state_t       state_o,
    output logic [DIV_W-1:0] div_q_o,
    output logic             clk_out
);
    div_state_t       st, st_n;
    logic [DIV_W-1:0] cnt, cnt_n;
    logic [DIV_W-1:0] div_q, div_q_n;
    logic [DIV_W-1:0] hi_new, lo_new, hi_cur, lo_cur;

    div_phase_len #(.DIV_W(DIV_W)) u_len_new (
        .div_f(div_in), .hi_m1(hi_new), .lo_m1(lo_new)
    );
    div_phase_len #(.DIV_W(DIV_W)) u_len_cur (
        .div_f(div_q), .hi_m1(hi_cur), .lo_m1(lo_cur)
    );

    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        div_q_n = div_q;
        unique case (st)
            ST_HIGH: begin
                if (cnt == '0) begin
                    st_n  = ST_LOW;
                    cnt_n = lo_cur;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_LOW: begin
                if (cnt == '0) begin
                    div_q_n = div_in;
                    st_n    = (div_in == '0) ? ST_PASS : ST_HIGH;
                    cnt_n   = hi_new;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_IDLE, ST_PASS: begin
                div_q_n = div_in;
                st_n    = (div_in == '0) ? ST_PASS : ST_HIGH;
                cnt_n   = hi_new;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            div_q <= '0;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            div_q <= div_q_n;
        end
    end

    always_comb begin
        unique case (st)
            ST_PASS: clk_out = clk;
            ST_HIGH: clk_out = 1'b1;
            default: clk_out = 1'b0;
        endcase
    end

    assign state_o = st;
    assign div_q_o = div_q;
    // hi_cur is unused by design: only the low reload needs the held field
    logic unused_hi;
    assign unused_hi = ^hi_cur;
endmodule

// File: rtl/prog_clkdiv.sv
module prog_clkdiv
    import prog_clkdiv_pkg::*;
(
    input  logic       clk_int,
    input  logic [2:0] ext_clk,
    input  logic [2:0] ext_pol,
    input  logic [1:0] src_sel,
    input  logic [7:0] div_val,
    input  logic       rst,
    output logic       clk_out
);
    localparam int NUM_EXT = 3;
    localparam int DIV_W   = 8;

    logic             clk_eff;
    div_state_t       st;
    logic [DIV_W-1:0] div_q;

    clk_src_mux #(.NUM_EXT(NUM_EXT)) u_mux (
        .clk_int(clk_int), .ext_clk(ext_clk), .ext_pol(ext_pol),
        .src_sel(src_sel), .clk_eff(clk_eff)
    );

    div_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk(clk_eff), .rst(rst), .div_in(div_val),
        .state_o(st), .div_q_o(div_q), .clk_out(clk_out)
    );
endmodule

// File: rtl/prog_clkdiv_chk.sv
module prog_clkdiv_chk
    import prog_clkdiv_pkg::*;
(
    input logic       clk_eff,
    input logic       rst,
    input div_state_t st,
    input logic [7:0] div_q,
    input logic [1:0] src_sel,
    input logic [2:0] ext_pol
);
    logic [8:0] hi_run, lo_run;
    logic       prev_hi, prev_lo;

    always_ff @(posedge clk_eff) begin
        if (rst) begin
            hi_run <= '0; lo_run <= '0; prev_hi <= 1'b0; prev_lo <= 1'b0;
        end else begin
            hi_run  <= (st == ST_HIGH) ? hi_run + 1'b1 : 9'd0;
            lo_run  <= (st == ST_LOW)  ? lo_run + 1'b1 : 9'd0;
            prev_hi <= (st == ST_HIGH);
            prev_lo <= (st == ST_LOW);
        end
    end

    p_reset_idle_r7: assert property (@(posedge clk_eff)
        rst |=> st == ST_IDLE);

    p_first_edge_r8: assert property (@(posedge clk_eff) disable iff (rst)
        (st == ST_IDLE) |=> (st == ST_HIGH || st == ST_PASS));

    p_high_len_r5: assert property (@(posedge clk_eff) disable iff (rst)
        (prev_hi && st == ST_LOW) |-> hi_run == {1'b0, div_q >> 1} + 9'd1);

    p_low_len_r4: assert property (@(posedge clk_eff) disable iff (rst)
        (prev_lo && st != ST_LOW) |->
            lo_run == {1'b0, $past(div_q)} - {1'b0, $past(div_q) >> 1});

    p_bypass_zero_r6: assert property (@(posedge clk_eff) disable iff (rst)
        (st == ST_PASS) |-> div_q == 8'd0);

    p_cfg_hold_r10: assert property (@(posedge clk_eff) disable iff (rst)
        $stable(src_sel) && $stable(ext_pol));
endmodule

bind prog_clkdiv prog_clkdiv_chk u_chk (
    .clk_eff(clk_eff), .rst(rst), .st(st), .div_q(div_q),
    .src_sel(src_sel), .ext_pol(ext_pol)
);

// File: tb/prog_clkdiv_tb.sv
module prog_clkdiv_tb;
    logic       clk_int = 1'b0;
    logic [2:0] ext_clk = 3'b000;
    logic [2:0] ext_pol = 3'b000;
    logic [1:0] src_sel = 2'd0;
    logic [7:0] div_val = 8'd0;
    logic       rst     = 1'b1;
    logic       clk_out;

    int total = 0;
    int bad   = 0;
    int pos   = 0;
    int nq    = 0;

    prog_clkdiv u_dut (
        .clk_int(clk_int), .ext_clk(ext_clk), .ext_pol(ext_pol),
        .src_sel(src_sel), .div_val(div_val), .rst(rst), .clk_out(clk_out)
    );

    always #10 clk_int = ~clk_int;                     // 50 MHz
    initial begin #3;  forever #10 ext_clk[0] = ~ext_clk[0]; end
    initial begin #7;  forever #15 ext_clk[1] = ~ext_clk[1]; end
    initial begin #11; forever #22 ext_clk[2] = ~ext_clk[2]; end

    // {sel, pol, div}
    localparam logic [12:0] VEC [9] = '{
        {2'd0, 3'b000, 8'd1},
        {2'd0, 3'b000, 8'd2},
        {2'd1, 3'b000, 8'd3},
        {2'd1, 3'b001, 8'd6},
        {2'd2, 3'b010, 8'd5},
        {2'd2, 3'b101, 8'd4},
        {2'd3, 3'b100, 8'd7},
        {2'd3, 3'b011, 8'd8},
        {2'd3, 3'b000, 8'd255}
    };

    task automatic chk(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic wait_edge(input logic active);
        logic fall;
        fall = (src_sel == 2'd0) ? 1'b0 : ext_pol[src_sel - 2'd1];
        if (!active) fall = ~fall;
        case (src_sel)
            2'd0: if (fall) @(negedge clk_int); else @(posedge clk_int);
            2'd1: if (fall) @(negedge ext_clk[0]); else @(posedge ext_clk[0]);
            2'd2: if (fall) @(negedge ext_clk[1]); else @(posedge ext_clk[1]);
            default: if (fall) @(negedge ext_clk[2]); else @(posedge ext_clk[2]);
        endcase
        #1;
    endtask

    task automatic do_reset(input logic [1:0] s, input logic [2:0] p,
                            input logic [7:0] d);
        rst = 1'b1;
        src_sel = s; ext_pol = p; div_val = d;
        for (int i = 0; i < 3; i++) wait_edge(1'b1);
        chk(clk_out, 1'b0, "R7 R10 low in reset");
        rst = 1'b0;
        pos = 0;
    endtask

    // independent period model: reload at pos 0, high for d/2+1 edges
    task automatic run_edges(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic e;
            wait_edge(1'b1);
            if (pos == 0) nq = int'(div_val);
            e = (pos < nq / 2 + 1);
            chk(clk_out, e, tag);
            pos = (pos + 1) % (nq + 1);
            wait_edge(1'b0);
            chk(clk_out, (nq == 0) ? 1'b0 : e, (nq == 0) ? "R6 bypass low" : "R2 inactive edge");
        end
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 R2 R3 R4 R5 R8: table across sources, polarities, ratios
        for (int v = 0; v < 9; v++) begin
            do_reset(VEC[v][12:11], VEC[v][10:8], VEC[v][7:0]);
            run_edges(2 * (int'(VEC[v][7:0]) + 1) + 2, "R1 R3 R4 R5 R8 active edge");
        end

        // R6: bypass, then leave it (R9: every bypass edge reloads)
        do_reset(2'd1, 3'b001, 8'd0);
        run_edges(5, "R6 bypass high");
        div_val = 8'd2;
        run_edges(7, "R9 exit bypass");

        // R9: change in mid period waits for the reload
        do_reset(2'd2, 3'b000, 8'd4);
        run_edges(2, "R9 before change");
        div_val = 8'd1;
        run_edges(8, "R9 after change");

        // R7: reset asserted while running
        do_reset(2'd0, 3'b000, 8'd5);
        run_edges(2, "R8 run before reset");
        rst = 1'b1;
        wait_edge(1'b1);
        chk(clk_out, 1'b0, "R7 reset while running");
        wait_edge(1'b1);
        chk(clk_out, 1'b0, "R7 reset held");

        // R10: reconfigure in reset to pin 2 falling, then run
        do_reset(2'd3, 3'b100, 8'd2);
        run_edges(6, "R10 new source");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule